// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Interface

This block sits between an interrupt distributor and a single processor core. Each cycle the distributor presents its best candidate: a valid flag, a 10-bit interrupt number and an 8-bit priority value, where a lower value means more urgent. The interface compares that priority against a programmable threshold. If the candidate qualifies, it raises an interrupt request line to the core.

Software reaches the interface through a small register port with four word selects: control, priority threshold, claim, and completion. Reading the claim select is a read with side effects. If a candidate qualifies, the read returns its number, pulses a claim strobe back to the distributor so that the pending state is dropped, and marks that interrupt as being serviced. If nothing qualifies, the read returns the spurious number 1023. Writing the same number to the completion select ends the service and pulses a done strobe so the distributor can deactivate it. Only one interrupt is serviced at a time. There is no preemption or nesting.

The controller is a two-state machine. In IDLE no interrupt is in service. A claim read that takes a qualifying candidate (transition TAKE) moves it to SERVING and latches the number. In SERVING, a completion write carrying the latched number (transition RETIRE) returns it to IDLE. A completion write with any other number (transition STRAY) leaves it in SERVING.

Top module: `ipr_ack_if`

## Requirements
- R1: After reset the request line is low, the control select reads 0 and the threshold select reads 0, so every interrupt is masked.
- R2: Bit 0 of the control select (select 0) enables signalling. While it is 0, irq_req stays low for every candidate. The control select reads back bit 0 only, with all other bits zero.
- R3: The threshold select (select 1) holds an 8-bit value in write-data bits [7:0]. While enabled and idle, irq_req is high exactly when a valid candidate has a priority value strictly below the threshold.
- R4: A claim read (select 2) that takes a candidate returns that candidate's number in read-data bits [9:0], with the upper bits zero. The data appears on reg_rdata one cycle after the read cycle.
- R5: A claim read when no candidate qualifies (not valid, priority not below the threshold, or signalling disabled) returns 1023. It produces no claim strobe and leaves the state unchanged.
- R6: A claim read that takes a candidate pulses claim_valid with claim_id equal to the number in the read cycle itself. From the next cycle irq_req is low.
- R7: A completion write (select 3, number in write-data bits [9:0]) that matches the serviced number pulses done_valid with done_id in the write cycle. The block then returns to idle, and irq_req reasserts on the next cycle if a qualifying candidate is present.
- R8: A completion write whose number differs from the serviced one is ignored: no done strobe, irq_req stays low, and a later claim read still returns 1023.
- R9: Candidate numbers 1020 to 1023 are reserved. They never raise irq_req and are never claimed.
- R10: While an interrupt is in service, a claim read returns 1023 and produces no claim strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Distributor has a candidate |
| cand_id | input | 10 | Candidate interrupt number |
| cand_prio | input | 8 | Candidate priority value (lower is more urgent) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Select: 0 control, 1 threshold, 2 claim, 3 completion |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_req | output | 1 | Interrupt request to the core |
| claim_valid | output | 1 | Claim strobe to the distributor |
| claim_id | output | 10 | Number being claimed |
| done_valid | output | 1 | Completion strobe to the distributor |
| done_id | output | 10 | Number being completed |

## Verification
A state machine stuck in SERVING shows up on the very next cycle: irq_req stays low and every claim read returns 1023 even with a qualifying candidate present. A machine that wrongly falls back to IDLE shows up just as quickly, as a second claim of a number already in service. A corrupted latched number shows up in the cycle of the completion write: the matching write raises no done strobe, or a mismatched write raises one. A wrong threshold or a wrong comparison edge is visible combinationally on irq_req. The bench therefore sweeps every priority value against several thresholds, and it exercises each state transition with a matching number, a stray number and a reserved number.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_CLAIM  = 2'd2,
        SEL_RETIRE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_SERVING = 1'b1
    } svc_state_e;

endpackage

// File: rtl/ipr_regs.sv
module ipr_regs #(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_thresh,
    input  logic              en_bit,
    input  logic [PRIO_W-1:0] thresh_val,
    output logic              enable,
    output logic [PRIO_W-1:0] thresh
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            thresh <= '0;
        end else begin
            if (wr_ctrl)   enable <= en_bit;
            if (wr_thresh) thresh <= thresh_val;
        end
    end

endmodule

// File: rtl/ipr_qual.sv
module ipr_qual #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8
) (
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              enable,
    input  logic [PRIO_W-1:0] thresh,
    input  logic              idle,
    output logic              eligible
);

    localparam logic [ID_W-1:0] SPURIOUS  = {ID_W{1'b1}};
    localparam logic [ID_W-1:0] RSV_FIRST = SPURIOUS - ID_W'(3);

    logic id_ok;
    logic prio_ok;

    always_comb begin
        id_ok    = (cand_id < RSV_FIRST);
        prio_ok  = (cand_prio < thresh);
        eligible = cand_valid && enable && idle && id_ok && prio_ok;
    end

endmodule

// File: rtl/ipr_fsm.sv
module ipr_fsm
    import ipr_pkg::*;
#(
    parameter int ID_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [ID_W-1:0] take_id,
    input  logic            retire_wr,
    input  logic [ID_W-1:0] retire_id,
    output logic            idle,
    output logic            done,
    output logic [ID_W-1:0] done_id
);

    svc_state_e      state_q, state_d;
    logic [ID_W-1:0] svc_id_q, svc_id_d;
    logic            id_match;

    always_comb begin
        id_match = (retire_id == svc_id_q);
        state_d  = state_q;
        svc_id_d = svc_id_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d  = ST_SERVING;
                    svc_id_d = take_id;
                end
            end
            ST_SERVING: begin
                if (retire_wr && id_match) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            svc_id_q <= '0;
        end else begin
            state_q  <= state_d;
            svc_id_q <= svc_id_d;
        end
    end

    always_comb begin
        idle    = (state_q == ST_IDLE);
        done    = (state_q == ST_SERVING) && retire_wr && id_match;
        done_id = svc_id_q;
    end

    assert_take_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state_q == ST_SERVING) && (svc_id_q == $past(take_id)));

    assert_stray_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVING && retire_wr && retire_id != svc_id_q)
        |=> (state_q == ST_SERVING) && $stable(svc_id_q));

    assert_retire_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE));

endmodule

// File: rtl/ipr_ack_if.sv
module ipr_ack_if
    import ipr_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic              claim_valid,
    output logic [ID_W-1:0]   claim_id,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id
);

    localparam logic [ID_W-1:0] SPURIOUS  = {ID_W{1'b1}};
    localparam logic [ID_W-1:0] RSV_FIRST = SPURIOUS - ID_W'(3);

    reg_sel_e          sel;
    logic              enable;
    logic [PRIO_W-1:0] thresh;
    logic              idle;
    logic              eligible;
    logic              claim_rd;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        sel         = reg_sel_e'(reg_sel);
        claim_rd    = reg_rd && (sel == SEL_CLAIM);
        claim_valid = claim_rd && eligible;
        claim_id    = cand_id;
        irq_req     = eligible;
    end

    ipr_regs #(.PRIO_W(PRIO_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (reg_wr && sel == SEL_CTRL),
        .wr_thresh  (reg_wr && sel == SEL_THRESH),
        .en_bit     (reg_wdata[0]),
        .thresh_val (reg_wdata[PRIO_W-1:0]),
        .enable     (enable),
        .thresh     (thresh)
    );

    ipr_qual #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_qual (
        .cand_valid (cand_valid),
        .cand_id    (cand_id),
        .cand_prio  (cand_prio),
        .enable     (enable),
        .thresh     (thresh),
        .idle       (idle),
        .eligible   (eligible)
    );

    ipr_fsm #(.ID_W(ID_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (claim_valid),
        .take_id   (cand_id),
        .retire_wr (reg_wr && sel == SEL_RETIRE),
        .retire_id (reg_wdata[ID_W-1:0]),
        .idle      (idle),
        .done      (done_valid),
        .done_id   (done_id)
    );

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_CTRL:   rd_mux[0] = enable;
            SEL_THRESH: rd_mux[PRIO_W-1:0] = thresh;
            SEL_CLAIM:  rd_mux[ID_W-1:0] = eligible ? cand_id : SPURIOUS;
            SEL_RETIRE: rd_mux = '0;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> enable);

    assert_irq_below_thresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cand_prio < thresh));

    assert_reserved_never_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cand_id < RSV_FIRST));

    assert_claim_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |=> (reg_rdata == DATA_W'($past(claim_id))));

    assert_empty_claim_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && !claim_valid) |=> (reg_rdata == DATA_W'(SPURIOUS)));

    assert_claim_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |=> !irq_req);

endmodule

// File: tb/ipr_ack_if_bench.sv
module ipr_ack_if_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic        claim_valid;
    logic [9:0]  claim_id;
    logic        done_valid;
    logic [9:0]  done_id;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ipr_ack_if u_ipr_ack_if (
        .clk(clk), .rst_n(rst_n),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req),
        .claim_valid(claim_valid), .claim_id(claim_id),
        .done_valid(done_valid), .done_id(done_id)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        #1;
    endtask

    task automatic read_reg(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = s;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
        d = reg_rdata;
    endtask

    task automatic claim_expect(input string req, input logic [31:0] exp_id, input bit exp_claim);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = 2'd2;
        #1;
        check({req, " claim strobe"}, 32'(claim_valid), 32'(exp_claim));
        if (exp_claim) check({req, " claim id"}, 32'(claim_id), exp_id);
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
        check({req, " claim data"}, reg_rdata, exp_id);
    endtask

    task automatic retire_expect(input string req, input logic [9:0] id, input bit exp_done);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'(id);
        #1;
        check({req, " done strobe"}, 32'(done_valid), 32'(exp_done));
        if (exp_done) check({req, " done id"}, 32'(done_id), 32'(id));
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  masks [5];
        masks[0] = 8'h00; masks[1] = 8'h01; masks[2] = 8'h80; masks[3] = 8'hF0; masks[4] = 8'hFF;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 irq after reset", 32'(irq_req), 0);
        read_reg(2'd0, rd); check("R1 control reset", rd, 0);
        read_reg(2'd1, rd); check("R1 threshold reset", rd, 0);

        // R2: enable gating
        cand_valid = 1'b1; cand_id = 10'd37; cand_prio = 8'h00;
        write_reg(2'd1, 32'h0000_00F0);
        check("R2 irq while disabled", 32'(irq_req), 0);
        write_reg(2'd0, 32'hFFFF_FFFF);
        read_reg(2'd0, rd); check("R2 control readback", rd, 1);
        check("R2 irq once enabled", 32'(irq_req), 1);

        // R3: sweep all priorities against several thresholds
        foreach (masks[k]) begin
            write_reg(2'd1, 32'(masks[k]));
            read_reg(2'd1, rd); check("R3 threshold readback", rd, 32'(masks[k]));
            for (int p = 0; p < 256; p++) begin
                @(negedge clk); cand_prio = 8'(p); #1;
                check("R3 priority compare", 32'(irq_req), 32'(p < int'(masks[k])));
            end
        end

        // R2: disabled sweep with the widest threshold
        write_reg(2'd0, 32'h0);
        for (int p = 0; p < 256; p++) begin
            @(negedge clk); cand_prio = 8'(p); #1;
            check("R2 disabled sweep", 32'(irq_req), 0);
        end
        cand_prio = 8'h00;
        claim_expect("R5 disabled", 32'd1023, 1'b0);
        write_reg(2'd0, 32'h1);

        // R9: reserved numbers
        write_reg(2'd1, 32'hF0);
        for (int id = 1016; id < 1024; id++) begin
            @(negedge clk); cand_id = 10'(id); #1;
            check("R9 reserved gating", 32'(irq_req), 32'(id < 1020));
        end
        cand_id = 10'd1021;
        claim_expect("R9 reserved claim", 32'd1023, 1'b0);

        // R4 R6: successful claim
        cand_id = 10'd37; cand_prio = 8'h10;
        claim_expect("R4 R6 claim 37", 32'd37, 1'b1);
        check("R6 irq drops", 32'(irq_req), 0);

        // R10: claim while serving
        claim_expect("R10 claim while serving", 32'd1023, 1'b0);

        // R8: stray completion
        retire_expect("R8 stray", 10'd38, 1'b0);
        check("R8 irq stays low", 32'(irq_req), 0);
        claim_expect("R8 claim after stray", 32'd1023, 1'b0);

        // R7: matching completion
        retire_expect("R7 retire 37", 10'd37, 1'b1);
        check("R7 irq reasserts", 32'(irq_req), 1);

        // R5: nothing qualifies
        cand_valid = 1'b0;
        claim_expect("R5 no candidate", 32'd1023, 1'b0);
        cand_valid = 1'b1; cand_prio = 8'hF0;
        claim_expect("R5 priority at threshold", 32'd1023, 1'b0);
        cand_prio = 8'h00; #1;
        check("R5 state unchanged", 32'(irq_req), 1);

        // R4 R7: claim/retire across number extremes
        foreach (masks[k]) begin
            logic [9:0] ids [4];
            ids[0] = 10'd0; ids[1] = 10'd1; ids[2] = 10'd511; ids[3] = 10'd1019;
            if (k < 4) begin
                cand_id = ids[k];
                claim_expect("R4 claim sweep", 32'(ids[k]), 1'b1);
                retire_expect("R7 retire sweep", ids[k], 1'b1);
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule